// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a stereo serial audio stream into parallel samples. It runs on the serial bit clock. On each rising edge it samples the frame-sync line and the data line. It rebuilds one left word and one right word per frame and presents them together as left-aligned 24-bit values, with a strobe that marks each new pair. Every format sends the most significant bit first.

A static select pin picks between the right-justified layout (pin low) and the I2S layout (pin high). Two cases are detected without software help:

- When the frame-sync high phase lasts four bit clocks or fewer, the receiver changes to a pulse-synchronised DSP layout. The same select pin then chooses the early variant or the late variant.
- When each frame-sync half period holds exactly 16 bit clocks, the receiver treats the words as 16 bits wide.

The detected layout and the detected word length are available as outputs.

Top module: `audio_ser_rx`

## Requirements
- R1: While `rst` is high and after it is released, `left_o` and `right_o` are zero, `valid_o` is low, `fmt_o` is 0 and `wlen_o` is 24, until the first stereo pair completes.
- R2: With `fmt_sel_i` high and a frame of 64 bit clocks, the MSB of each word is sampled on the second rising edge after a frame-sync transition. A low frame sync marks the left word and a high frame sync marks the right word, and 24 bits are taken per word.
- R3: With `fmt_sel_i` high and 16 bit clocks per half period, a 16-bit word is received. It appears in bits 23..8 with bits 7..0 zero, and `wlen_o` reads 16.
- R4: With `fmt_sel_i` low, each word is the last 24 bits sampled before the frame-sync transition that ends its half period. Earlier bits in that half period have no effect.
- R5: With `fmt_sel_i` low and 16 bit clocks per half period, the last 16 bits of each half period appear in bits 23..8 with bits 7..0 zero, and `wlen_o` reads 16. In every non-DSP layout, `wlen_o` reads only 16 or 24.
- R6: With `fmt_sel_i` high and 24 bit clocks per half period, the LSB of each word is sampled on the first edge of the following half period. `wlen_o` reads 24.
- R7: A frame-sync high phase of 1 to 4 bit clocks selects the DSP layout. `fmt_o` then reads 2 (early) when `fmt_sel_i` is low and 3 (late) when it is high. In DSP, words are 24 bits and `wlen_o` reads 24.
- R8: In early DSP, the left MSB is sampled on the first rising edge that sees frame sync high. Then 24 left bits follow, and then 24 right bits follow at once.
- R9: In late DSP, every bit is sampled one edge later than in early DSP.
- R10: `valid_o` is high for exactly one bit clock, in the cycle after the edge that samples the right word's LSB. `left_o` and `right_o` change only together with that pulse. Exactly one pulse occurs per DSP frame.
- R11: A frame-sync high phase of 5 bit clocks is not taken as DSP. `fmt_o` reads 1 with `fmt_sel_i` high, and stereo pairs are still delivered.
- In `fmt_o`: 0 means right-justified, 1 means I2S, 2 means DSP early and 3 means DSP late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync (level per channel, or a short pulse in DSP) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_sel_i | input | 1 | Static layout select: low right-justified / early DSP, high I2S / late DSP |
| left_o | output | 24 | Last complete left word, left-aligned |
| right_o | output | 24 | Last complete right word, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| fmt_o | output | 2 | Detected layout code |
| wlen_o | output | 5 | Detected word length, 16 or 24 |

## Verification
In the level-synchronised layouts, a pair becomes visible one cycle after the edge that detects the frame-sync fall. That edge also samples the I2S right LSB when the half period equals the word length. In DSP, a pair becomes visible one cycle after the edge at offset 47 (early) or 48 (late) from the sync rise. The bench drives inputs on falling edges. It records `valid_o` and the samples on falling edges, so each captured value belongs to exactly one completed pair. Every scenario sends several identical frames, then one closing edge, then idle edges, before it compares the last captured pair against values computed from the chosen bit layout.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic [1:0] {
    FMT_RJ        = 2'd0,
    FMT_I2S       = 2'd1,
    FMT_DSP_EARLY = 2'd2,
    FMT_DSP_LATE  = 2'd3
  } asr_fmt_e;
endpackage

// File: rtl/asr_frame_track.sv
// Follows frame-sync edges and position counters in bit clocks.
module asr_frame_track #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic [POS_W-1:0] old_len_o,  // length of the half period just ended
  output logic [POS_W-1:0] hpos_o,     // position of this edge in current half
  output logic [POS_W-1:0] fpos_o      // position of this edge since sync rise
);
  logic             sync_q;
  logic [POS_W-1:0] hpos_q, fpos_q;
  logic [POS_W-1:0] hinc, finc;

  assign hinc      = (hpos_q == '1) ? hpos_q : hpos_q + 1'b1;
  assign finc      = (fpos_q == '1) ? fpos_q : fpos_q + 1'b1;
  assign rise_o    = sync_i & ~sync_q;
  assign fall_o    = ~sync_i & sync_q;
  assign old_len_o = hinc;
  assign hpos_o    = (rise_o | fall_o) ? '0 : hinc;
  assign fpos_o    = rise_o ? '0 : finc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      hpos_q <= '0;
      fpos_q <= '0;
    end else begin
      sync_q <= sync_i;
      hpos_q <= hpos_o;
      fpos_q <= fpos_o;
    end
  end

  // R2: a new half period always begins counting at zero
  a_r2_half_restart: assert property (@(posedge clk) disable iff (rst)
    (rise_o | fall_o) |=> (hpos_q == '0));
endmodule

// File: rtl/asr_lr_lane.sv
// Builds words for the level-synchronised layouts (I2S and right-justified).
module asr_lr_lane #(
  parameter int WORD_W = 24,
  parameter int POS_W  = 8,
  parameter int PACK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata_i,
  input  logic              trans_i,
  input  logic              i2s_i,
  input  logic [POS_W-1:0]  old_len_i,
  input  logic [POS_W-1:0]  hpos_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int PAD_W = WORD_W - PACK_W;

  logic [WORD_W-1:0] acc_q, acc_wr, sr_q, i2s_word, rj_word;
  logic [POS_W-1:0]  p, idx_full;
  logic              packed16;

  assign p        = trans_i ? old_len_i : hpos_i;
  assign idx_full = POS_W'(WORD_W) - p;
  assign packed16 = (old_len_i == POS_W'(PACK_W));

  always_comb begin
    acc_wr = acc_q;
    if (p >= POS_W'(1) && p <= POS_W'(WORD_W))
      acc_wr[idx_full[IDX_W-1:0]] = sdata_i;
  end

  assign i2s_word = packed16 ? {acc_wr[WORD_W-1:PAD_W], {PAD_W{1'b0}}} : acc_wr;
  assign rj_word  = packed16 ? {sr_q[PACK_W-1:0], {PAD_W{1'b0}}} : sr_q;
  assign word_o   = i2s_i ? i2s_word : rj_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sr_q  <= '0;
    end else begin
      acc_q <= trans_i ? '0 : acc_wr;
      sr_q  <= {sr_q[WORD_W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/asr_dsp_lane.sv
// Builds the left and right words that follow a short sync pulse back to back.
module asr_dsp_lane #(
  parameter int WORD_W = 24,
  parameter int POS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata_i,
  input  logic              late_i,
  input  logic [POS_W-1:0]  fpos_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] l_q, r_q;
  logic [POS_W-1:0]  k, li, ri;
  logic              in_frame;

  assign in_frame = (fpos_i >= POS_W'(late_i));
  assign k        = fpos_i - POS_W'(late_i);
  assign li       = POS_W'(WORD_W - 1) - k;
  assign ri       = POS_W'(2 * WORD_W - 1) - k;
  assign done_o   = in_frame && (k == POS_W'(2 * WORD_W - 1));

  always_comb begin
    left_o  = l_q;
    right_o = r_q;
    if (in_frame && k < POS_W'(WORD_W))
      left_o[li[IDX_W-1:0]] = sdata_i;
    else if (in_frame && k < POS_W'(2 * WORD_W))
      right_o[ri[IDX_W-1:0]] = sdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_q <= '0;
      r_q <= '0;
    end else begin
      l_q <= left_o;
      r_q <= right_o;
    end
  end
endmodule

// File: rtl/audio_ser_rx.sv
module audio_ser_rx #(
  parameter int WORD_W  = 24,
  parameter int POS_W   = 8,
  parameter int DSP_MAX = 4,
  parameter int PACK_W  = 16,
  parameter int WL_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              sdata_i,
  input  logic              fmt_sel_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic [1:0]        fmt_o,
  output logic [WL_W-1:0]   wlen_o
);
  import asr_pkg::*;

  logic              rise, fall, dsp_done, short_hi;
  logic [POS_W-1:0]  old_len, hpos, fpos;
  logic [WORD_W-1:0] lane_word, dsp_l, dsp_r;
  logic [WORD_W-1:0] left_q, right_q, hold_left;
  logic              valid_q, dsp_q;
  asr_fmt_e          fmt_q;
  logic [WL_W-1:0]   wl_q;

  asr_frame_track #(.POS_W(POS_W)) u_track (
    .clk(clk), .rst(rst), .sync_i(sync_i),
    .rise_o(rise), .fall_o(fall), .old_len_o(old_len),
    .hpos_o(hpos), .fpos_o(fpos)
  );

  asr_lr_lane #(.WORD_W(WORD_W), .POS_W(POS_W), .PACK_W(PACK_W)) u_lr (
    .clk(clk), .rst(rst), .sdata_i(sdata_i), .trans_i(rise | fall),
    .i2s_i(fmt_sel_i), .old_len_i(old_len), .hpos_i(hpos), .word_o(lane_word)
  );

  asr_dsp_lane #(.WORD_W(WORD_W), .POS_W(POS_W)) u_dsp (
    .clk(clk), .rst(rst), .sdata_i(sdata_i), .late_i(fmt_sel_i),
    .fpos_i(fpos), .left_o(dsp_l), .right_o(dsp_r), .done_o(dsp_done)
  );

  assign short_hi = (old_len <= POS_W'(DSP_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      right_q   <= '0;
      hold_left <= '0;
      valid_q   <= 1'b0;
      dsp_q     <= 1'b0;
      fmt_q     <= FMT_RJ;
      wl_q      <= WL_W'(WORD_W);
    end else begin
      valid_q <= 1'b0;
      if (rise && !dsp_q)
        hold_left <= lane_word;
      if (fall) begin
        if (!short_hi && !dsp_q) begin
          left_q  <= hold_left;
          right_q <= lane_word;
          valid_q <= 1'b1;
        end
        dsp_q <= short_hi;
        if (short_hi) begin
          fmt_q <= fmt_sel_i ? FMT_DSP_LATE : FMT_DSP_EARLY;
          wl_q  <= WL_W'(WORD_W);
        end else begin
          fmt_q <= fmt_sel_i ? FMT_I2S : FMT_RJ;
          wl_q  <= (old_len == POS_W'(PACK_W)) ? WL_W'(PACK_W) : WL_W'(WORD_W);
        end
      end
      if (dsp_q && dsp_done) begin
        left_q  <= dsp_l;
        right_q <= dsp_r;
        valid_q <= 1'b1;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign fmt_o   = fmt_q;
  assign wlen_o  = wl_q;

  // R10: strobe lasts a single bit clock
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R10: samples move only together with the strobe
  a_r10_left_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(left_q) |-> valid_q);
  a_r10_right_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(right_q) |-> valid_q);
  // R7: DSP layouts report full-width words
  a_r7_dsp_width: assert property (@(posedge clk) disable iff (rst)
    fmt_q[1] |-> (wl_q == WL_W'(WORD_W)));
  // R5: only two word lengths are ever reported
  a_r5_wlen_legal: assert property (@(posedge clk) disable iff (rst)
    (wl_q == WL_W'(WORD_W)) || (wl_q == WL_W'(PACK_W)));
endmodule

// File: tb/audio_ser_rx_test.sv
module audio_ser_rx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        fmt_sel_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;
  logic [1:0]  fmt_o;
  logic [4:0]  wlen_o;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [23:0] cap_l = '0, cap_r = '0;
  logic        prev_valid = 1'b0;
  logic [23:0] last_l = '0, last_r = '0;
  bit          mon_on = 1'b0;
  bit          sy [0:127];
  bit          dv [0:127];

  audio_ser_rx uut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .sdata_i(sdata_i),
    .fmt_sel_i(fmt_sel_i), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .fmt_o(fmt_o), .wlen_o(wlen_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Observer on falling edges: strobe capture and R10 strobe/stability rules
  always @(negedge clk) begin
    if (mon_on) begin
      if (valid_o) begin
        vcount++;
        cap_l = left_o;
        cap_r = right_o;
        if (prev_valid) begin
          errors++;
          $display("FAIL R10: actual strobe width 2 expected 1");
        end
      end else if (left_o !== last_l || right_o !== last_r) begin
        errors++;
        $display("FAIL R10: actual change %h/%h expected %h/%h",
                 left_o, right_o, last_l, last_r);
      end
      prev_valid = valid_o;
      last_l = left_o;
      last_r = right_o;
    end
  end

  task automatic drive(input bit s, input bit d);
    @(negedge clk);
    sync_i  = s;
    sdata_i = d;
  endtask

  // mode 0: I2S, 1: right-justified, 2: DSP (delay d)
  task automatic send(input int nlow, input int nhigh, input int w, input int mode,
                      input int d, input logic [23:0] lw, input logic [23:0] rw,
                      input int nframes);
    int t = nlow + nhigh;
    for (int i = 0; i < t; i++) begin
      dv[i] = (mode == 1);
      sy[i] = (mode == 2) ? (i < nhigh) : (i >= nlow);
    end
    for (int j = 0; j < w; j++) begin
      if (mode == 0) begin
        dv[(1 + j) % t]        = lw[w-1-j];
        dv[(nlow + 1 + j) % t] = rw[w-1-j];
      end else if (mode == 1) begin
        dv[nlow - w + j] = lw[w-1-j];
        dv[t - w + j]    = rw[w-1-j];
      end else begin
        dv[d + j]     = lw[w-1-j];
        dv[d + w + j] = rw[w-1-j];
      end
    end
    vcount = 0;
    for (int f = 0; f < nframes; f++)
      for (int i = 0; i < t; i++) drive(sy[i], dv[i]);
    drive(sy[0], dv[0]);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 left", left_o, 24'h0);
    check("R1 right", right_o, 24'h0);
    check("R1 valid", {23'h0, valid_o}, 24'h0);
    check("R1 fmt", {22'h0, fmt_o}, 24'd0);
    check("R1 wlen", {19'h0, wlen_o}, 24'd24);
    last_l = left_o;
    last_r = right_o;
    mon_on = 1'b1;
  endtask

  task automatic t_i2s64;
    fmt_sel_i = 1'b1;
    send(32, 32, 24, 0, 0, 24'hA5C3E1, 24'h1E2D3C, 3);
    check("R2 left", cap_l, 24'hA5C3E1);
    check("R2 right", cap_r, 24'h1E2D3C);
    check("R2 fmt", {22'h0, fmt_o}, 24'd1);
    check("R2 pairs", (vcount >= 2) ? 24'd1 : 24'd0, 24'd1);
  endtask

  task automatic t_i2s32;
    fmt_sel_i = 1'b1;
    send(16, 16, 16, 0, 0, 24'h00B3F1, 24'h004C2E, 3);
    check("R3 left", cap_l, 24'hB3F100);
    check("R3 right", cap_r, 24'h4C2E00);
    check("R3 wlen", {19'h0, wlen_o}, 24'd16);
  endtask

  task automatic t_i2s48;
    fmt_sel_i = 1'b1;
    send(24, 24, 24, 0, 0, 24'h800001, 24'h7FFFFE, 3);
    check("R6 left", cap_l, 24'h800001);
    check("R6 right", cap_r, 24'h7FFFFE);
    check("R6 wlen", {19'h0, wlen_o}, 24'd24);
  endtask

  task automatic t_rj64;
    fmt_sel_i = 1'b0;
    send(32, 32, 24, 1, 0, 24'h123456, 24'h0F0F0F, 3);
    check("R4 left", cap_l, 24'h123456);
    check("R4 right", cap_r, 24'h0F0F0F);
    check("R4 fmt", {22'h0, fmt_o}, 24'd0);
  endtask

  task automatic t_rj32;
    fmt_sel_i = 1'b0;
    send(16, 16, 16, 1, 0, 24'h00C001, 24'h003FFE, 3);
    check("R5 left", cap_l, 24'hC00100);
    check("R5 right", cap_r, 24'h3FFE00);
    check("R5 wlen", {19'h0, wlen_o}, 24'd16);
  endtask

  task automatic t_wide_pulse;
    fmt_sel_i = 1'b1;
    send(59, 5, 24, 0, 0, 24'h0, 24'h0, 3);
    check("R11 fmt", {22'h0, fmt_o}, 24'd1);
    check("R11 pairs", (vcount >= 2) ? 24'd1 : 24'd0, 24'd1);
  endtask

  task automatic t_dsp_early;
    fmt_sel_i = 1'b0;
    send(63, 1, 24, 2, 0, 24'hF00D15, 24'h0BEEF7, 3);
    check("R8 left", cap_l, 24'hF00D15);
    check("R8 right", cap_r, 24'h0BEEF7);
    check("R7 fmt early", {22'h0, fmt_o}, 24'd2);
    check("R7 wlen", {19'h0, wlen_o}, 24'd24);
    check("R10 one per frame", 24'(vcount), 24'd3);
  endtask

  task automatic t_dsp_late;
    fmt_sel_i = 1'b1;
    send(60, 4, 24, 2, 1, 24'h3C5A96, 24'hC3A569, 2);
    check("R9 left", cap_l, 24'h3C5A96);
    check("R9 right", cap_r, 24'hC3A569);
    check("R7 fmt late", {22'h0, fmt_o}, 24'd3);
    check("R10 one per frame late", 24'(vcount), 24'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s64();
    t_i2s32();
    t_i2s48();
    t_rj64();
    t_rj32();
    t_wide_pulse();
    t_dsp_early();
    t_dsp_late();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule